// File: doc/BRIEF.md
# Paired-Block UART Interrupt Aggregator

This block collects interrupt events from four two-channel serial blocks and turns them into two level-sensitive interrupt request lines. Each block keeps an 8-bit event status byte and an 8-bit enable mask. Channel logic raises and lowers the transmit-ready, receive-ready and break events through per-channel set and clear strobes. Software reads the status through a small register port and writes the masks through the same port.

Each request line covers one adjacent pair of blocks. It is high while either block in that pair has a status bit whose mask bit is also set. A vectored acknowledge read returns an 8-bit vector that software programs. The vector is loaded through address 1 of the identification space or of the memory space. The acknowledge address selects the line being acknowledged. The lines are combinational functions of registered state, so every edge that changes a status or mask value takes effect on the lines in the cycle that follows it.

Top module: `irqagg_top`

## Requirements
- R1: While reset is asserted and after it is released, every status byte, every mask and the vector read as zero, both `irq` lines are low and `rdata` is zero.
- R2: Channel n belongs to block n/2. In a block's status byte the even channel uses bit 0 for transmit-ready, bit 1 for receive-ready and bit 2 for break. The odd channel uses bits 4, 5 and 6 for the same three events. Bits 3 and 7 always read 0.
- R3: A set strobe makes its status bit 1 at the next clock edge and a clear strobe makes it 0. If both strobes reach the same bit in one cycle, the set wins.
- R4: `reg_wr` loads `wdata` into the mask of the block chosen by `reg_sel`. It leaves every status byte unchanged. `reg_rd` returns the status byte of the chosen block, not its mask.
- R5: `irq[l]` is high exactly when (status AND mask) is nonzero in block 2l or in block 2l+1. It follows the registered state in the same cycle, with no extra delay.
- R6: An acknowledge read at address 0 or address 2 returns the stored vector. An acknowledge read at any other address returns 0. An acknowledge read changes no status.
- R7: A write with `id_wr` or `mem_wr` at `sp_addr` 1 loads `wdata` into the vector. Writes in those spaces at any other address leave the vector unchanged.
- R8: `rdata` is combinational. It is zero when no read strobe is high. When `reg_rd` and `ack_rd` are both high, the register read takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_tx | input | 8 | Per-channel transmit-ready set strobes |
| clr_tx | input | 8 | Per-channel transmit-ready clear strobes |
| set_rx | input | 8 | Per-channel receive-ready set strobes |
| clr_rx | input | 8 | Per-channel receive-ready clear strobes |
| set_brk | input | 8 | Per-channel break set strobes |
| clr_brk | input | 8 | Per-channel break clear strobes |
| reg_sel | input | 2 | Block selected by the register port |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Mask write strobe |
| wdata | input | 8 | Write data for the mask and vector writes |
| id_wr | input | 1 | Identification-space write strobe |
| mem_wr | input | 1 | Memory-space write strobe |
| sp_addr | input | 8 | Address for identification-space and memory-space writes |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_addr | input | 8 | Acknowledge address |
| irq | output | 2 | Level-sensitive interrupt request lines |
| rdata | output | 8 | Read data |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a set strobe and a clear strobe on the same status bit. The second pair is a mask write and a status change in the same block. The directed phases force both pairs on purpose. The random phase also produces them often, because it draws set strobes, clear strobes and mask writes independently each cycle. The bench judges each case against a behavioural model in which the set wins and the mask and status both update at the same edge. It compares `irq` and `rdata` on every cycle, so a line that lags or leads by one cycle is caught.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int ST_W     = 8;
   localparam int EV_PER_CH = 3;
   localparam int CH_STRIDE = 4;
   localparam int EV_TX    = 0;
   localparam int EV_RX    = 1;
   localparam int EV_BRK   = 2;
   localparam int TIE_CNT  = 3;
   localparam int TIE_IPC  = 7;
endpackage

// File: rtl/irqagg_blk.sv
module irqagg_blk
   import irqagg_pkg::*;
#(
   parameter int CH_PER_BLK = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CH_PER_BLK-1:0] set_tx,
   input  logic [CH_PER_BLK-1:0] clr_tx,
   input  logic [CH_PER_BLK-1:0] set_rx,
   input  logic [CH_PER_BLK-1:0] clr_rx,
   input  logic [CH_PER_BLK-1:0] set_brk,
   input  logic [CH_PER_BLK-1:0] clr_brk,
   input  logic                  mask_we,
   input  logic [ST_W-1:0]       mask_wd,
   output logic [ST_W-1:0]       status,
   output logic [ST_W-1:0]       mask,
   output logic                  pend
);
   localparam int MAX_CH = ST_W / CH_STRIDE;

   if (CH_PER_BLK != MAX_CH) begin : g_bad_ch
      $error("irqagg_blk: CH_PER_BLK must equal %0d", MAX_CH);
   end

   logic [EV_PER_CH-1:0] ev_q [CH_PER_BLK];

   for (genvar c = 0; c < CH_PER_BLK; c++) begin : g_ch
      logic [EV_PER_CH-1:0] set_v, clr_v, nxt;
      assign set_v = {set_brk[c], set_rx[c], set_tx[c]};
      assign clr_v = {clr_brk[c], clr_rx[c], clr_tx[c]};
      assign nxt   = set_v | (ev_q[c] & ~clr_v);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ev_q[c] <= '0;
         else        ev_q[c] <= nxt;
      end

      assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
         set_tx[c] |=> status[c*CH_STRIDE + EV_TX]);
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_rx[c] && !set_rx[c]) |=> !status[c*CH_STRIDE + EV_RX]);
   end

   always_comb begin
      status = '0;
      for (int c = 0; c < CH_PER_BLK; c++) begin
         status[c*CH_STRIDE +: EV_PER_CH] = ev_q[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_wd;
   end

   assign pend = |(status & mask);

   assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask == $past(mask_wd)));
   assert_tied_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !status[TIE_CNT] && !status[TIE_IPC]);
endmodule

// File: rtl/irqagg_vec.sv
module irqagg_vec #(
   parameter int ADDR_W    = 8,
   parameter int VEC_W     = 8,
   parameter int NUM_LINES = 2,
   parameter int VEC_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_wr,
   input  logic              mem_wr,
   input  logic [ADDR_W-1:0] sp_addr,
   input  logic [VEC_W-1:0]  wdata,
   input  logic              ack_rd,
   input  logic [ADDR_W-1:0] ack_addr,
   output logic              ack_hit,
   output logic [VEC_W-1:0]  ack_data
);
   logic [VEC_W-1:0] vec_q;
   logic             load;

   assign load = (id_wr || mem_wr) && (sp_addr == ADDR_W'(VEC_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    vec_q <= '0;
      else if (load) vec_q <= wdata;
   end

   assign ack_hit  = ack_rd && !ack_addr[0] && ((ack_addr >> 1) < ADDR_W'(NUM_LINES));
   assign ack_data = ack_hit ? vec_q : '0;

   assert_vec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (vec_q == $past(wdata)));
   assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(vec_q));
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
   parameter int NUM_BLK = 4
) (
   input  logic [NUM_BLK-1:0]   pend,
   output logic [NUM_BLK/2-1:0] irq
);
   for (genvar l = 0; l < NUM_BLK/2; l++) begin : g_line
      assign irq[l] = pend[2*l] | pend[2*l+1];
   end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int NUM_BLK = 4,
   parameter int ADDR_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [2*NUM_BLK-1:0]          set_tx,
   input  logic [2*NUM_BLK-1:0]          clr_tx,
   input  logic [2*NUM_BLK-1:0]          set_rx,
   input  logic [2*NUM_BLK-1:0]          clr_rx,
   input  logic [2*NUM_BLK-1:0]          set_brk,
   input  logic [2*NUM_BLK-1:0]          clr_brk,
   input  logic [$clog2(NUM_BLK)-1:0]    reg_sel,
   input  logic                          reg_rd,
   input  logic                          reg_wr,
   input  logic [7:0]                    wdata,
   input  logic                          id_wr,
   input  logic                          mem_wr,
   input  logic [ADDR_W-1:0]             sp_addr,
   input  logic                          ack_rd,
   input  logic [ADDR_W-1:0]             ack_addr,
   output logic [NUM_BLK/2-1:0]          irq,
   output logic [7:0]                    rdata
);
   localparam int CPB       = 2;
   localparam int NUM_LINES = NUM_BLK / 2;

   if (NUM_BLK < 2 || (NUM_BLK % 2) != 0) begin : g_bad_blk
      $error("irqagg_top: NUM_BLK must be even and at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("irqagg_top: ADDR_W too small");
   end

   logic [ST_W-1:0]    status [NUM_BLK];
   logic [ST_W-1:0]    mask   [NUM_BLK];
   logic [NUM_BLK-1:0] pend;
   logic               ack_hit;
   logic [ST_W-1:0]    ack_data;

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      irqagg_blk #(.CH_PER_BLK(CPB)) u_blk (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_tx  (set_tx [b*CPB +: CPB]),
         .clr_tx  (clr_tx [b*CPB +: CPB]),
         .set_rx  (set_rx [b*CPB +: CPB]),
         .clr_rx  (clr_rx [b*CPB +: CPB]),
         .set_brk (set_brk[b*CPB +: CPB]),
         .clr_brk (clr_brk[b*CPB +: CPB]),
         .mask_we (reg_wr && (reg_sel == b)),
         .mask_wd (wdata),
         .status  (status[b]),
         .mask    (mask[b]),
         .pend    (pend[b])
      );
   end

   irqagg_line #(.NUM_BLK(NUM_BLK)) u_line (
      .pend (pend),
      .irq  (irq)
   );

   irqagg_vec #(
      .ADDR_W    (ADDR_W),
      .VEC_W     (ST_W),
      .NUM_LINES (NUM_LINES),
      .VEC_ADDR  (1)
   ) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .id_wr    (id_wr),
      .mem_wr   (mem_wr),
      .sp_addr  (sp_addr),
      .wdata    (wdata),
      .ack_rd   (ack_rd),
      .ack_addr (ack_addr),
      .ack_hit  (ack_hit),
      .ack_data (ack_data)
   );

   always_comb begin
      if (reg_rd)      rdata = status[reg_sel];
      else if (ack_rd) rdata = ack_data;
      else             rdata = '0;
   end

   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd && !ack_rd) |-> (rdata == '0));
   assert_ack_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !reg_rd && !ack_hit) |-> (rdata == '0));
   assert_line0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (((status[0] & mask[0]) | (status[1] & mask[1])) == '0) |-> !irq[0]);
   assert_ack_nochange_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && set_tx == '0 && clr_tx == '0) |=> $stable(status[0][0]));
endmodule

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
   localparam int NB = 4;
   localparam int NC = 8;
   localparam int NL = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic [NC-1:0] set_tx, clr_tx, set_rx, clr_rx, set_brk, clr_brk;
   logic [1:0]    reg_sel;
   logic          reg_rd, reg_wr, id_wr, mem_wr, ack_rd;
   logic [7:0]    wdata, sp_addr, ack_addr;
   logic [NL-1:0] irq;
   logic [7:0]    rdata;

   irqagg_top uut (
      .clk(clk), .rst_n(rst_n),
      .set_tx(set_tx), .clr_tx(clr_tx), .set_rx(set_rx), .clr_rx(clr_rx),
      .set_brk(set_brk), .clr_brk(clr_brk),
      .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .wdata(wdata),
      .id_wr(id_wr), .mem_wr(mem_wr), .sp_addr(sp_addr),
      .ack_rd(ack_rd), .ack_addr(ack_addr),
      .irq(irq), .rdata(rdata)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;
   string tag   = "R1";

   int m_ev [NC][3];
   int m_mask [NB];
   int m_vec;

   function automatic int st(int b);
      int v = 0;
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < 3; k++) begin
            if (m_ev[2*b+c][k] != 0) v |= (1 << (c*4 + k));
         end
      end
      return v;
   endfunction

   function automatic int nxt(int cur, logic s, logic c);
      if (s) return 1;
      if (c) return 0;
      return cur;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int ch = 0; ch < NC; ch++) for (int k = 0; k < 3; k++) m_ev[ch][k] = 0;
         for (int b = 0; b < NB; b++) m_mask[b] = 0;
         m_vec = 0;
      end else begin
         for (int ch = 0; ch < NC; ch++) begin
            m_ev[ch][0] = nxt(m_ev[ch][0], set_tx[ch],  clr_tx[ch]);
            m_ev[ch][1] = nxt(m_ev[ch][1], set_rx[ch],  clr_rx[ch]);
            m_ev[ch][2] = nxt(m_ev[ch][2], set_brk[ch], clr_brk[ch]);
         end
         if (reg_wr) m_mask[reg_sel] = int'(wdata);
         if ((id_wr || mem_wr) && sp_addr == 8'd1) m_vec = int'(wdata);
      end
   end

   task automatic chk(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         int er;
         int ei;
         if (reg_rd)      er = st(int'(reg_sel));
         else if (ack_rd) er = (ack_addr == 8'd0 || ack_addr == 8'd2) ? m_vec : 0;
         else             er = 0;
         ei = 0;
         for (int l = 0; l < NL; l++) begin
            if (((st(2*l) & m_mask[2*l]) | (st(2*l+1) & m_mask[2*l+1])) != 0) ei |= (1 << l);
         end
         chk("rdata", int'(rdata), er);
         chk("irq", int'(irq), ei);
      end
   end

   task automatic idle_in();
      set_tx = '0; clr_tx = '0; set_rx = '0; clr_rx = '0; set_brk = '0; clr_brk = '0;
      reg_sel = '0; reg_rd = 0; reg_wr = 0; wdata = '0; id_wr = 0; mem_wr = 0;
      sp_addr = '0; ack_rd = 0; ack_addr = '0;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic read_all();
      for (int b = 0; b < NB; b++) begin
         idle_in(); reg_rd = 1; reg_sel = 2'(b); step();
      end
      idle_in();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      idle_in();
      rst_n = 0;
      tag = "R1 reset";
      repeat (3) step();
      rst_n = 1;
      read_all();
      ack_rd = 1; ack_addr = 8'd0; step(); idle_in();

      tag = "R2 layout";
      for (int ch = 0; ch < NC; ch++) begin
         set_tx = NC'(1 << ch); step(); idle_in();
         reg_rd = 1; reg_sel = 2'(ch / 2); step();
         idle_in(); set_rx = NC'(1 << ch); step();
         idle_in(); set_brk = NC'(1 << ch); reg_rd = 1; reg_sel = 2'(ch / 2); step();
         idle_in(); reg_rd = 1; reg_sel = 2'(ch / 2); step();
         idle_in(); clr_tx = '1; clr_rx = '1; clr_brk = '1; step();
         idle_in();
      end

      tag = "R3 set-clear collision";
      set_rx = 8'hA5; step(); idle_in();
      set_rx = 8'h0F; clr_rx = 8'hFF; set_brk = 8'h30; clr_brk = 8'h30; step();
      idle_in(); read_all();
      clr_rx = 8'hFF; clr_brk = 8'hFF; step(); idle_in(); read_all();

      tag = "R4 mask write";
      for (int b = 0; b < NB; b++) begin
         reg_wr = 1; reg_sel = 2'(b); wdata = 8'hFF; step(); idle_in();
      end
      read_all();
      set_tx = 8'h01; step(); idle_in();
      reg_wr = 1; reg_sel = 2'd0; wdata = 8'h00; set_tx = 8'h02; step(); idle_in();
      read_all();

      tag = "R5 line combine";
      clr_tx = '1; step(); idle_in();
      reg_wr = 1; reg_sel = 2'd0; wdata = 8'h22; step(); idle_in();
      set_rx = 8'h08; step(); idle_in();
      set_rx = 8'h10; step(); idle_in();
      set_brk = 8'h80; step(); idle_in();
      clr_rx = 8'h08; step(); idle_in();
      clr_rx = 8'h10; step(); idle_in();
      clr_brk = 8'h80; step(); idle_in();
      reg_wr = 1; reg_sel = 2'd2; wdata = 8'h00; set_tx = 8'h10; step(); idle_in();
      reg_wr = 1; reg_sel = 2'd2; wdata = 8'h01; step(); idle_in();
      clr_tx = 8'h10; step(); idle_in();

      tag = "R7 vector load";
      id_wr = 1; sp_addr = 8'd1; wdata = 8'h5C; step(); idle_in();
      id_wr = 1; sp_addr = 8'd0; wdata = 8'h11; step(); idle_in();
      mem_wr = 1; sp_addr = 8'd3; wdata = 8'h22; step(); idle_in();
      ack_rd = 1; ack_addr = 8'd0; step(); idle_in();
      mem_wr = 1; sp_addr = 8'd1; wdata = 8'hC3; step(); idle_in();

      tag = "R6 acknowledge";
      set_rx = 8'hFF; step(); idle_in();
      for (int a = 0; a < 6; a++) begin
         ack_rd = 1; ack_addr = 8'(a); step(); idle_in();
      end
      read_all();

      tag = "R8 read priority";
      reg_rd = 1; ack_rd = 1; reg_sel = 2'd3; ack_addr = 8'd2; step(); idle_in();
      step();

      tag = "R2 R3 R4 R5 R6 R7 R8 random";
      for (int i = 0; i < 4000; i++) begin
         idle_in();
         set_tx  = 8'($urandom) & 8'($urandom) & 8'($urandom);
         clr_tx  = 8'($urandom) & 8'($urandom) & 8'($urandom);
         set_rx  = 8'($urandom) & 8'($urandom) & 8'($urandom);
         clr_rx  = 8'($urandom) & 8'($urandom) & 8'($urandom);
         set_brk = 8'($urandom) & 8'($urandom) & 8'($urandom);
         clr_brk = 8'($urandom) & 8'($urandom) & 8'($urandom);
         reg_sel = 2'($urandom);
         reg_rd  = ($urandom % 3) == 0;
         reg_wr  = ($urandom % 6) == 0;
         wdata   = 8'($urandom);
         id_wr   = ($urandom % 8) == 0;
         mem_wr  = ($urandom % 8) == 0;
         sp_addr = 8'($urandom % 4);
         ack_rd  = ($urandom % 3) == 0;
         ack_addr = 8'($urandom % 6);
         step();
      end
      idle_in();
      step();

      done = 1;
      summary();
      $finish;
   end
endmodule